// File: doc/BRIEF.md
# Maskable Sticky Interrupt Aggregator

This block gathers eight interrupt sources into a bank of sticky status bits and drives one combined interrupt line toward the processor. Each source is watched for a rising edge. The edge sets its status bit whatever the mask holds, and the bit stays set until software clears it. A per-source enable mask decides which set bits reach the combined line.

Software works through a small word-wide register port. The mask is read and written at one select. The status word is read at a second select, where a written 1 forces the matching bit set, for testing the interrupt path. A third select is write-only and clears every bit written as 1. The most significant bit of the status view is read-only and shows the live level of the core interrupt input. The address decoding of whatever bus carries these accesses, and the filters that condition the hot-plug and sense events, sit outside this block.

Top module: `irq_sticky_agg`

## Requirements
- R1: After reset the mask and all status bits are 0, `irq_o` is 0, and every register select reads 0 except bit 31 of the status view.
- R2: A 0-to-1 change on `src_i[n]` sets status bit n at the next clock edge. Bit 0 is the core interrupt, bit 1 hot-plug rise, bit 2 hot-plug fall, bit 3 nonce refresh, bit 4 random-number error, bit 5 I2C timeout, bit 6 sense rise and bit 7 sense fall. A level that stays high does not set the bit again after a clear.
- R3: A status bit sets on its source edge even when its mask bit is 0.
- R4: `irq_o` is 1 exactly when some status bit and its mask bit (1 enables) are both 1.
- R5: A write at select 1 (status) sets every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: A write at select 2 (clear) clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: A read at select 1 returns the status in bits 7:0, the live level of `src_i[0]` in bit 31, and 0 elsewhere. Writes to bit 31 have no effect.
- R8: When a source edge and a clear of the same bit fall in the same cycle, the bit ends set.
- R9: Select 0 holds the mask in bits 7:0 and reads 0 above them. Select 2 and select 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 8 | Source levels, rising edge captured |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 status, 2 clear, 3 spare |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default eight sources and a 32-bit data word. With these values the live core level lands at bit 31 of the status view, so the ignored high write bit and the read-only level can both be observed. Every one of the eight source positions is driven, including all eight rising at once. The vectors also put a source edge and a clear of the same bit in one cycle, and they release a source that stays high after its bit is cleared.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register selects on the word-wide register port.
    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_rise_capture.sv
module irq_rise_capture #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = src_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rise
        assign rise_o[g] = src_i[g] & ~cap_q.prev[g];
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_en_i,
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] status_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] status;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    logic [NUM_SRC-1:0] force_set;
    logic [NUM_SRC-1:0] clear_req;

    always_comb begin
        force_set = '0;
        clear_req = '0;
        bank_d    = bank_q;

        if (wr_en_i) begin
            case (sel_i)
                SEL_MASK:   bank_d.mask = wdata_i;
                SEL_STATUS: force_set   = wdata_i;
                SEL_CLEAR:  clear_req   = wdata_i;
                default:    ;
            endcase
        end

        // Hardware edges are applied after the clear so that they win.
        bank_d.status = ((bank_q.status | force_set) & ~clear_req) | rise_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o   = bank_q.mask;
    assign status_o = bank_q.status;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int DATA_W       = 32,
    parameter int CORE_LVL_BIT = DATA_W - 1
) (
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic               core_lvl_i,
    output logic [DATA_W-1:0]  rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_MASK: rdata_o[NUM_SRC-1:0] = mask_i;
            SEL_STATUS: begin
                rdata_o[NUM_SRC-1:0]  = status_i;
                rdata_o[CORE_LVL_BIT] = core_lvl_i;
            end
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int DATA_W       = 32,
    parameter int CORE_LVL_BIT = DATA_W - 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] status_w;
    logic               unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_addr_i);
    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];

    irq_rise_capture #(
        .NUM_SRC(NUM_SRC)
    ) i_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .rise_o (rise_w)
    );

    irq_status_bank #(
        .NUM_SRC(NUM_SRC)
    ) i_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise_w),
        .wr_en_i  (reg_we_i),
        .sel_i    (sel),
        .wdata_i  (reg_wdata_i[NUM_SRC-1:0]),
        .mask_o   (mask_w),
        .status_o (status_w)
    );

    irq_read_mux #(
        .NUM_SRC      (NUM_SRC),
        .DATA_W       (DATA_W),
        .CORE_LVL_BIT (CORE_LVL_BIT)
    ) i_rmux (
        .sel_i      (sel),
        .mask_i     (mask_w),
        .status_i   (status_w),
        .core_lvl_i (src_i[0]),
        .rdata_o    (reg_rdata_o)
    );

    assign irq_o = |(status_w & mask_w);

endmodule

// File: rtl/irq_sticky_agg_chk.sv
module irq_sticky_agg_chk #(
    parameter int NUM_SRC      = 8,
    parameter int DATA_W       = 32,
    parameter int CORE_LVL_BIT = DATA_W - 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic               reg_we_i,
    input logic [1:0]         reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask_w,
    input logic [NUM_SRC-1:0] status_w
);

    logic [NUM_SRC-1:0] src_seen;
    logic [NUM_SRC-1:0] rise_c;
    logic [NUM_SRC-1:0] wlo;
    logic               armed;
    logic               wr_stat;
    logic               wr_clr;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_seen <= '0;
            armed    <= 1'b0;
        end else begin
            src_seen <= src_i;
            armed    <= 1'b1;
        end
    end

    assign rise_c  = src_i & ~src_seen;
    assign wlo     = reg_wdata_i[NUM_SRC-1:0];
    assign wr_stat = reg_we_i && (reg_addr_i == 2'd1);
    assign wr_clr  = reg_we_i && (reg_addr_i == 2'd2);

    // R2, R3, R8: an edge sets its bit, mask and clear notwithstanding
    p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> ((status_w & $past(rise_c)) == $past(rise_c)));

    // R8: set wins when the same bit is cleared in the same cycle
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && $past(wr_clr)) |-> ((status_w & $past(rise_c & wlo)) == $past(rise_c & wlo)));

    // R6: cleared bits without a simultaneous edge read 0
    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && $past(wr_clr)) |-> ((status_w & $past(wlo & ~rise_c)) == '0));

    // R5: forced bits are set
    p_force_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && $past(wr_stat)) |-> ((status_w & $past(wlo)) == $past(wlo)));

    // R2: sticky, bits only fall through a clear write
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && !$past(wr_clr)) |-> ((status_w & $past(status_w)) == $past(status_w)));

    // R4: no enabled set bit means a quiet line
    p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_w & mask_w) == '0) |-> !irq_o);

    // R4: an enabled set bit raises the line
    p_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_w & mask_w) != '0) |-> irq_o);

    // R7: status view carries the live core level
    p_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == 2'd1) |-> (reg_rdata_o[CORE_LVL_BIT] == src_i[0]));

    // R9: clear and spare selects read 0
    p_zero_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i[1]) |-> (reg_rdata_o == '0));

endmodule

bind irq_sticky_agg irq_sticky_agg_chk #(
    .NUM_SRC      (NUM_SRC),
    .DATA_W       (DATA_W),
    .CORE_LVL_BIT (CORE_LVL_BIT)
) i_irq_sticky_agg_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .mask_w      (mask_w),
    .status_w    (status_w)
);

// File: tb/test_irq_sticky_agg.sv
module test_irq_sticky_agg;

    localparam int NSRC = 8;
    localparam int DW   = 32;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic            we;
        logic [1:0]      addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   exp_rd;   // status view after the step
        logic            exp_irq;
    } vec_t;

    // Each step: drive inputs for one clock, then read the status view.
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R1 idle
        '{8'h02, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0002, 1'b0}, // R2 R3 hot-plug rise, masked
        '{8'h02, 1'b1, 2'd0, 32'h0000_00FF, 32'h0000_0002, 1'b1}, // R4 enable all
        '{8'h02, 1'b1, 2'd2, 32'h0000_0002, 32'h0000_0000, 1'b0}, // R6 R2 clear, level held
        '{8'h03, 1'b0, 2'd0, 32'h0000_0000, 32'h8000_0001, 1'b1}, // R7 core rises, live bit
        '{8'h00, 1'b1, 2'd1, 32'h8000_0070, 32'h0000_0071, 1'b1}, // R5 R7 force, bit31 ignored
        '{8'h00, 1'b1, 2'd2, 32'h0000_0001, 32'h0000_0070, 1'b1}, // R6 clear bit 0
        '{8'h00, 1'b1, 2'd0, 32'h0000_000F, 32'h0000_0070, 1'b0}, // R4 narrow mask
        '{8'h80, 1'b1, 2'd2, 32'h0000_0080, 32'h0000_00F0, 1'b0}, // R8 edge vs clear
        '{8'h80, 1'b1, 2'd2, 32'h0000_00F0, 32'h0000_0000, 1'b0}, // R6 clear upper
        '{8'h00, 1'b1, 2'd1, 32'h0000_0008, 32'h0000_0008, 1'b1}, // R5 force bit 3
        '{8'h00, 1'b1, 2'd1, 32'h0000_0000, 32'h0000_0008, 1'b1}, // R5 zeros no effect
        '{8'h00, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_0008, 1'b1}, // R6 zeros no effect
        '{8'h00, 1'b1, 2'd2, 32'h0000_0008, 32'h0000_0000, 1'b0}  // R6 line drops
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            we = 1'b0;
    logic [1:0]      addr = 2'd0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    irq_sticky_agg i_irq_sticky_agg (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic [NSRC-1:0] s, input logic w, input logic [1:0] a,
                        input logic [DW-1:0] d);
        @(negedge clk);
        src = s; we = w; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 2'd1; wdata = '0;
        #1;
    endtask

    task automatic read_at(input logic [1:0] a);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        addr = 2'd1; #1;
        check("R1 status", rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        read_at(2'd0);
        check("R1 mask", rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].src, VEC[i].we, VEC[i].addr, VEC[i].wdata);
            check($sformatf("R2-vec%0d status", i), rdata, VEC[i].exp_rd);
            check($sformatf("R4-vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
        end

        // R9: mask readback, clear and spare read zero
        read_at(2'd0);
        check("R9 mask read", rdata, 32'h0000_000F);
        read_at(2'd2);
        check("R9 clear read", rdata, 32'h0);
        read_at(2'd3);
        check("R9 spare read", rdata, 32'h0);

        // R2: all eight sources rise together, all enabled
        step(8'h00, 1'b1, 2'd0, 32'hFFFF_FFFF);
        check("R9 mask upper ignored", rdata, 32'h0);
        read_at(2'd0);
        check("R9 mask all", rdata, 32'h0000_00FF);
        step(8'hFF, 1'b0, 2'd0, 32'h0);
        check("R2 all rise", rdata, 32'h8000_00FF);
        check("R4 all rise irq", {31'b0, irq}, 32'h1);

        // R1: reset mid-run returns everything to zero
        @(negedge clk);
        rst_n = 1'b0; src = 8'h00;
        @(negedge clk);
        #1;
        check("R1 re-reset status", rdata, 32'h0);
        check("R1 re-reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        read_at(2'd0);
        check("R1 re-reset mask", rdata, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule